// File: doc/BRIEF.md
# Infrared Carrier Synthesizer with Output Gating

The block produces an infrared carrier from the system clock, which runs at half the oscillator rate. A static 3-bit select chooses one of eight divide ratios. The carrier is high for one third of each period. Two control bits key the carrier onto a single output pin, so that software can build a remote-control pulse train by toggling them in time with its own timer. One bit enables modulation. The other bit sets the output level.

While the carrier is not being emitted, its divider is held cleared. Each burst therefore starts at the beginning of a carrier period. The output is taken from a flip-flop, so the pin never carries a combinational glitch.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `ir_out` is 0 and the divider is cleared.
- R2: The carrier period, in system clocks, depends on `ratio_sel`: 000→6, 001→36, 010→50, 011→53, 100→56, 101→61, 110→64, 111→74. For example, with a 2 MHz system clock (a 4 MHz oscillator) and code 010, the carrier is 40 kHz.
- R3: Within each period, the output is high for floor(N/3) system clocks and low for the remaining clocks, where N is the period from R2.
- R4: When `car_en` and `out_lvl` are both 1, `ir_out` carries the carrier. On the first clock edge at which both are 1, the output goes high and a full high phase begins.
- R5: When `car_en` is 1 and `out_lvl` is 0, `ir_out` is 0 after the next clock edge.
- R6: When `car_en` is 0, `ir_out` takes the value of `out_lvl` at the next clock edge.
- R7: A change of `ratio_sel` during a burst takes effect only at the next period boundary. The current period finishes with the old ratio.
- R8: Whenever either gate bit is 0, the divider is held cleared. Re-enabling the carrier in the middle of a period restarts it with a complete high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (oscillator / 2) |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 3 | Divide ratio select code |
| car_en | input | 1 | Carrier modulation enable |
| out_lvl | input | 1 | Output level / carrier gate |
| ir_out | output | 1 | Registered infrared output |

## Verification
Every result is due exactly one clock edge after the inputs that cause it, because the output passes through a single flip-flop. The first high of a burst also follows one edge after both gate bits are 1. The driver changes inputs on the falling edge and queues the value the output must show after the following rising edge. The monitor compares that value 2 ns after the rising edge, so each expectation lines up with the one register stage. A ratio change made mid-burst is expected only after the counted period ends.

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_sel,
  input  logic       car_en,
  input  logic       out_lvl,
  output logic       ir_out
);

  logic [2:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ratio;
  logic [CW-1:0] hi_len;
  logic          gate;
  logic          last;

  function automatic logic [CW-1:0] div_of(input logic [2:0] code);
    case (code)
      3'd0:    div_of = CW'(6);
      3'd1:    div_of = CW'(36);
      3'd2:    div_of = CW'(50);
      3'd3:    div_of = CW'(53);
      3'd4:    div_of = CW'(56);
      3'd5:    div_of = CW'(61);
      3'd6:    div_of = CW'(64);
      default: div_of = CW'(74);
    endcase
  endfunction

  assign ratio  = div_of(sel_q);
  assign hi_len = ratio / CW'(3);
  assign gate   = car_en & out_lvl;
  assign last   = (cnt == ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sel_q  <= '0;
      ir_out <= 1'b0;
    end else begin
      if (!gate || last) begin
        cnt   <= '0;
        sel_q <= ratio_sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
      ir_out <= car_en ? (out_lvl & (cnt < hi_len)) : out_lvl;
    end
  end

  AST_LEVEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !car_en |=> ir_out == $past(out_lvl)); // R6

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    car_en && !out_lvl |=> !ir_out); // R5

  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |=> ir_out); // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio); // R2

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gate && !last |=> $stable(sel_q)); // R7

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> cnt == '0); // R8

endmodule

// File: tb/tb_ir_carrier_gen.sv
module tb_ir_carrier_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ratio_sel = 3'd0;
  logic       car_en = 1'b0;
  logic       out_lvl = 1'b0;
  logic       ir_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  int m_cnt = 0;
  int m_n = 6;

  always #5 clk = ~clk;

  ir_carrier_gen dut (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
    .car_en(car_en), .out_lvl(out_lvl), .ir_out(ir_out)
  );

  function automatic int tab(input logic [2:0] c);
    case (c)
      3'd0: return 6;  3'd1: return 36; 3'd2: return 50; 3'd3: return 53;
      3'd4: return 56; 3'd5: return 61; 3'd6: return 64; default: return 74;
    endcase
  endfunction

  task automatic step(input bit en, input bit lvl, input logic [2:0] sel, input string tag);
    bit e;
    @(negedge clk);
    car_en = en; out_lvl = lvl; ratio_sel = sel;
    if (!(en && lvl)) begin
      e = en ? 1'b0 : lvl;
      m_cnt = 0; m_n = tab(sel);
    end else begin
      e = (m_cnt < m_n / 3);
      if (m_cnt == m_n - 1) begin m_cnt = 0; m_n = tab(sel); end
      else m_cnt++;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (ir_out !== e) begin
          errors++;
          $display("FAIL %s: ir_out=%b expected=%b at %0t", t, ir_out, e, $time);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (ir_out !== 1'b0) begin
      errors++; $display("FAIL R1: ir_out=%b expected=0 in reset", ir_out);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    checks++;
    if (ir_out !== 1'b0) begin
      errors++; $display("FAIL R1: ir_out=%b expected=0 after reset", ir_out);
    end

    // R6: level follows when modulation is off
    for (int i = 0; i < 6; i++) step(1'b0, i[1], 3'd2, "R6");
    // R5: forced low
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 3'd2, "R5");

    // R2, R3, R4: every ratio, two full periods each
    for (int s = 0; s < 8; s++) begin
      step(1'b0, 1'b0, 3'(s), "R8");
      step(1'b1, 1'b1, 3'(s), "R4");
      for (int k = 1; k < 2 * tab(3'(s)) + 3; k++)
        step(1'b1, 1'b1, 3'(s), (k % tab(3'(s)) < tab(3'(s)) / 3) ? "R3" : "R2");
    end

    // R7: change select mid-period
    step(1'b1, 1'b0, 3'd2, "R5");
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 3'd2, "R4");
    for (int k = 0; k < 60; k++) step(1'b1, 1'b1, 3'd0, "R7");

    // R8: drop gate in low and in high phase, then restart
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 3'd0, "R8");
    step(1'b0, 1'b1, 3'd0, "R6");
    for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 3'd0, "R8");
    step(1'b1, 1'b1, 3'd1, "R8");
    step(1'b1, 1'b0, 3'd1, "R5");
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 3'd1, "R8");
    step(1'b0, 1'b0, 3'd1, "R6");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule